// File: doc/BRIEF.md
# Coprocessor TLB-Invalidate Access Arbiter

This block decides what happens when software issues one particular coprocessor-space system operation: invalidate the last-level translation entries that match a given address and address-space identifier. Each cycle it may receive an encoding, the current privilege level and a set of hypervisor control bits. It resolves them into exactly one outcome: the encoding is not the one this block handles, the access is undefined, the access traps to level 2, or a TLB invalidate request is issued. An issued request carries the translation regime, the VMID select, the shareability scope and the XS attribute filter.

The decision itself is combinational. The result is captured in a register on the clock edge that samples the valid strobe, so every result appears one cycle after its strobe. Outcome flags last for a single cycle. The detail fields hold their values until the next strobe. Exception entry and the TLB are handled by neighbouring blocks, which consume these outputs.

Top module: `sysop_gate`

## Requirements
- R1: When `valid_i` is high at a rising clock edge, `out_vld` is high after that edge and the outputs reflect the inputs sampled at that edge. When `valid_i` is low at a rising edge, `out_vld` and all four outcome flags are low after that edge. Strobes may arrive back to back.
- R2: The operation is recognised only for coproc=4'b1111, opc1=3'b000, crn=4'b1000, crm=4'b0111 and opc2=3'b101. Any other encoding gives `unhandled`=1 and no other flag, whatever the privilege level and control bits are.
- R3: For a recognised encoding at privilege level 0 (`priv_lvl`=2'd0), the result is `undef`=1.
- R4: At level 1 with `l2_en`=1, the result is a trap if `crn8_trap`=1 or `tlb_trap`=1. The CRn-8 bit has priority and the TLB bit is checked next. The trap has `trap_code`=6'h03 and `trap_wide`=`l2_wide` (1 = route for a 64-bit level 2, 0 = route for a 32-bit level 2). When `l2_en`=0, neither bit has any effect.
- R5: At level 1, when no trap applies, a request is issued with `req_regime`=0 (level-1/0 regime) and `req_vmid_cur`=1. `req_inner`=1 (inner-shareable) only when `l2_en`=1 and `force_bcast`=1. Otherwise `req_inner`=0 (non-shareable).
- R6: At level 1, `req_excl_xs`=1 only when `l2_en`, `l2_wide`, `xs_feat`, `ext_en` and `no_xs` are all 1. Otherwise it is 0 and all attributes are included.
- R7: At level 2, the result is a request with regime 0, `req_vmid_cur`=1, `req_inner`=0 and `req_excl_xs`=0, regardless of the trap and control bits.
- R8: At level 3, the result is a request with `req_regime`=1 (level-3 regime), `req_vmid_cur`=0, `req_inner`=0 and `req_excl_xs`=0.
- R9: Every issued request has `req_last`=1, meaning last-level entries only.
- R10: With `out_vld` high, exactly one of `unhandled`, `undef`, `trap` and `req` is high. Trap detail fields are 0 unless `trap` is high, and request detail fields are 0 unless `req` is high.
- R11: While `rst_n` is low, every output is 0. Release of `rst_n` is synchronised internally over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe: sample the operation this cycle |
| coproc | input | 4 | Coprocessor number of the encoding |
| opc1 | input | 3 | First opcode field |
| crn | input | 4 | Primary register field |
| crm | input | 4 | Secondary register field |
| opc2 | input | 3 | Second opcode field |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| l2_en | input | 1 | Level 2 enabled |
| l2_wide | input | 1 | Level 2 runs in the 64-bit state |
| crn8_trap | input | 1 | Hypervisor trap bit for CRn=8 accesses |
| tlb_trap | input | 1 | Hypervisor trap bit for TLB maintenance |
| force_bcast | input | 1 | Force broadcast to the inner-shareable domain |
| xs_feat | input | 1 | XS attribute and extended-control features present |
| ext_en | input | 1 | Extended hypervisor control enabled |
| no_xs | input | 1 | Extended control: leave XS entries untouched |
| out_vld | output | 1 | A result is present this cycle |
| unhandled | output | 1 | Encoding is not the handled operation |
| undef | output | 1 | Access is undefined |
| trap | output | 1 | Access traps to level 2 |
| trap_wide | output | 1 | Trap route: 1 for a 64-bit level 2, 0 for a 32-bit level 2 |
| trap_code | output | 6 | Syndrome code of the trap |
| req | output | 1 | Invalidate request issued |
| req_regime | output | 1 | 0: level-1/0 regime, 1: level-3 regime |
| req_vmid_cur | output | 1 | 1: current VMID, 0: no VMID |
| req_inner | output | 1 | 1: inner-shareable, 0: non-shareable |
| req_excl_xs | output | 1 | 1: exclude XS entries, 0: all attributes |
| req_last | output | 1 | Last-level entries only |

## Verification
Every result is due exactly one rising edge after its strobe. The bench therefore drives inputs on a falling edge and compares all outputs on the next falling edge, after the single capturing edge and before the following one. The main sweep keeps `valid_i` high over consecutive cycles, so each comparison also shows that the previous result has been replaced. Idle cycles inserted between strobes check that the flags drop one edge after `valid_i` falls. Reset is checked asynchronously, while `rst_n` is still low, and again in the middle of a run. After each release the bench waits out the two-edge synchroniser before it applies stimulus.

// File: rtl/sysop_pkg.sv
package sysop_pkg;

  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } lvl_e;

  typedef struct packed {
    logic              unhandled;
    logic              undef;
    logic              trap;
    logic              trap_wide;
    logic [CODE_W-1:0] trap_code;
    logic              req;
    logic              regime;
    logic              vmid_cur;
    logic              inner;
    logic              excl_xs;
    logic              last;
  } result_t;

endpackage

// File: rtl/sysop_match.sv
module sysop_match #(
  parameter logic [3:0] COPROC_ID = 4'b1111,
  parameter logic [2:0] OPC1_ID   = 3'b000,
  parameter logic [3:0] CRN_ID    = 4'b1000,
  parameter logic [3:0] CRM_ID    = 4'b0111,
  parameter logic [2:0] OPC2_ID   = 3'b101
) (
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit_o
);

  logic [4:0] fld_eq;

  always_comb begin
    fld_eq[0] = (coproc == COPROC_ID);
    fld_eq[1] = (opc1   == OPC1_ID);
    fld_eq[2] = (crn    == CRN_ID);
    fld_eq[3] = (crm    == CRM_ID);
    fld_eq[4] = (opc2   == OPC2_ID);
    hit_o     = &fld_eq;
  end

endmodule

// File: rtl/sysop_trap.sv
module sysop_trap
  import sysop_pkg::*;
#(
  parameter logic [CODE_W-1:0] TRAP_CODE = 6'h03
) (
  input  logic [1:0]        lvl_i,
  input  logic              l2_en_i,
  input  logic              l2_wide_i,
  input  logic              crn8_trap_i,
  input  logic              tlb_trap_i,
  output logic              trap_o,
  output logic              wide_o,
  output logic [CODE_W-1:0] code_o
);

  logic at_l1_hyp;
  logic by_crn8;
  logic by_tlb;

  always_comb begin
    at_l1_hyp = (lvl_i == LVL1) && l2_en_i;
    // the CRn-8 bit is examined first; the TLB bit only when it is clear
    by_crn8   = at_l1_hyp && crn8_trap_i;
    by_tlb    = at_l1_hyp && !crn8_trap_i && tlb_trap_i;
    trap_o    = by_crn8 || by_tlb;
    wide_o    = trap_o && l2_wide_i;
    code_o    = trap_o ? TRAP_CODE : '0;
  end

  always_comb begin
    if (trap_o) begin
      assert_trap_gate_R4: assert (lvl_i == LVL1 && l2_en_i && (crn8_trap_i || tlb_trap_i));
    end
  end

endmodule

// File: rtl/sysop_inval.sv
module sysop_inval
  import sysop_pkg::*;
(
  input  logic [1:0] lvl_i,
  input  logic       l2_en_i,
  input  logic       l2_wide_i,
  input  logic       force_bcast_i,
  input  logic       xs_feat_i,
  input  logic       ext_en_i,
  input  logic       no_xs_i,
  output logic       regime_o,
  output logic       vmid_cur_o,
  output logic       inner_o,
  output logic       excl_xs_o
);

  logic xs_ctl_live;

  always_comb begin
    xs_ctl_live = l2_en_i && l2_wide_i && xs_feat_i && ext_en_i && no_xs_i;
    regime_o    = 1'b0;
    vmid_cur_o  = 1'b0;
    inner_o     = 1'b0;
    excl_xs_o   = 1'b0;
    unique case (lvl_i)
      LVL1: begin
        vmid_cur_o = 1'b1;
        inner_o    = l2_en_i && force_bcast_i;
        excl_xs_o  = xs_ctl_live;
      end
      LVL2: begin
        vmid_cur_o = 1'b1;
      end
      LVL3: begin
        regime_o   = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_comb begin
    if (excl_xs_o) begin
      assert_xs_gate_R6: assert (lvl_i == LVL1 && l2_wide_i && no_xs_i);
    end
  end

endmodule

// File: rtl/sysop_gate.sv
module sysop_gate
  import sysop_pkg::*;
#(
  parameter logic [3:0]        COPROC_ID = 4'b1111,
  parameter logic [2:0]        OPC1_ID   = 3'b000,
  parameter logic [3:0]        CRN_ID    = 4'b1000,
  parameter logic [3:0]        CRM_ID    = 4'b0111,
  parameter logic [2:0]        OPC2_ID   = 3'b101,
  parameter logic [CODE_W-1:0] TRAP_CODE = 6'h03,
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        coproc,
  input  logic [2:0]        opc1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        opc2,
  input  logic [1:0]        priv_lvl,
  input  logic              l2_en,
  input  logic              l2_wide,
  input  logic              crn8_trap,
  input  logic              tlb_trap,
  input  logic              force_bcast,
  input  logic              xs_feat,
  input  logic              ext_en,
  input  logic              no_xs,
  output logic              out_vld,
  output logic              unhandled,
  output logic              undef,
  output logic              trap,
  output logic              trap_wide,
  output logic [CODE_W-1:0] trap_code,
  output logic              req,
  output logic              req_regime,
  output logic              req_vmid_cur,
  output logic              req_inner,
  output logic              req_excl_xs,
  output logic              req_last
);

  // reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STG-1];

  logic              hit;
  logic              trap_c;
  logic              trap_wide_c;
  logic [CODE_W-1:0] trap_code_c;
  logic              regime_c;
  logic              vmid_cur_c;
  logic              inner_c;
  logic              excl_xs_c;

  sysop_match #(
    .COPROC_ID (COPROC_ID),
    .OPC1_ID   (OPC1_ID),
    .CRN_ID    (CRN_ID),
    .CRM_ID    (CRM_ID),
    .OPC2_ID   (OPC2_ID)
  ) u_match (
    .coproc (coproc),
    .opc1   (opc1),
    .crn    (crn),
    .crm    (crm),
    .opc2   (opc2),
    .hit_o  (hit)
  );

  sysop_trap #(
    .TRAP_CODE (TRAP_CODE)
  ) u_trap (
    .lvl_i       (priv_lvl),
    .l2_en_i     (l2_en),
    .l2_wide_i   (l2_wide),
    .crn8_trap_i (crn8_trap),
    .tlb_trap_i  (tlb_trap),
    .trap_o      (trap_c),
    .wide_o      (trap_wide_c),
    .code_o      (trap_code_c)
  );

  sysop_inval u_inval (
    .lvl_i         (priv_lvl),
    .l2_en_i       (l2_en),
    .l2_wide_i     (l2_wide),
    .force_bcast_i (force_bcast),
    .xs_feat_i     (xs_feat),
    .ext_en_i      (ext_en),
    .no_xs_i       (no_xs),
    .regime_o      (regime_c),
    .vmid_cur_o    (vmid_cur_c),
    .inner_o       (inner_c),
    .excl_xs_o     (excl_xs_c)
  );

  // outcome selection: encoding first, then level, then hypervisor traps
  result_t decided;

  always_comb begin
    decided = '0;
    if (!hit) begin
      decided.unhandled = 1'b1;
    end else if (priv_lvl == LVL0) begin
      decided.undef = 1'b1;
    end else if (trap_c) begin
      decided.trap      = 1'b1;
      decided.trap_wide = trap_wide_c;
      decided.trap_code = trap_code_c;
    end else begin
      decided.req      = 1'b1;
      decided.regime   = regime_c;
      decided.vmid_cur = vmid_cur_c;
      decided.inner    = inner_c;
      decided.excl_xs  = excl_xs_c;
      decided.last     = 1'b1;
    end
  end

  // next state: flags pulse for one cycle, details load only on a strobe
  result_t res_q;
  result_t res_d;
  logic    vld_q;

  always_comb begin
    res_d           = res_q;
    res_d.unhandled = 1'b0;
    res_d.undef     = 1'b0;
    res_d.trap      = 1'b0;
    res_d.req       = 1'b0;
    if (valid_i) res_d = decided;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      res_q <= res_d;
    end
  end

  assign out_vld      = vld_q;
  assign unhandled    = res_q.unhandled;
  assign undef        = res_q.undef;
  assign trap         = res_q.trap;
  assign trap_wide    = res_q.trap_wide;
  assign trap_code    = res_q.trap_code;
  assign req          = res_q.req;
  assign req_regime   = res_q.regime;
  assign req_vmid_cur = res_q.vmid_cur;
  assign req_inner    = res_q.inner;
  assign req_excl_xs  = res_q.excl_xs;
  assign req_last     = res_q.last;

  assert_strobe_to_result_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    valid_i |=> out_vld);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !valid_i |=> !(unhandled || undef || trap || req));

  assert_foreign_enc_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (valid_i && !hit) |=> (unhandled && !undef && !trap && !req));

  assert_lvl0_undef_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (valid_i && hit && priv_lvl == LVL0) |=> undef);

  assert_syndrome_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    trap |-> (trap_code == TRAP_CODE));

  assert_lvl3_regime_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (valid_i && hit && priv_lvl == LVL3) |=> (req && req_regime && !req_vmid_cur));

  assert_last_level_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    req |-> req_last);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_vld |-> ($countones({unhandled, undef, trap, req}) == 1));

endmodule

// File: tb/test_sysop_gate.sv
`timescale 1ns/1ps
module test_sysop_gate;

  logic       clk;
  logic       rst_n;
  logic       valid_i;
  logic [3:0] coproc;
  logic [2:0] opc1;
  logic [3:0] crn;
  logic [3:0] crm;
  logic [2:0] opc2;
  logic [1:0] priv_lvl;
  logic       l2_en, l2_wide, crn8_trap, tlb_trap, force_bcast, xs_feat, ext_en, no_xs;
  logic       out_vld, unhandled, undef, trap, trap_wide, req;
  logic [5:0] trap_code;
  logic       req_regime, req_vmid_cur, req_inner, req_excl_xs, req_last;

  int n_chk;
  int n_bad;
  bit done;

  sysop_gate i_sysop_gate (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .coproc(coproc), .opc1(opc1), .crn(crn), .crm(crm), .opc2(opc2),
    .priv_lvl(priv_lvl), .l2_en(l2_en), .l2_wide(l2_wide),
    .crn8_trap(crn8_trap), .tlb_trap(tlb_trap), .force_bcast(force_bcast),
    .xs_feat(xs_feat), .ext_en(ext_en), .no_xs(no_xs),
    .out_vld(out_vld), .unhandled(unhandled), .undef(undef), .trap(trap),
    .trap_wide(trap_wide), .trap_code(trap_code), .req(req),
    .req_regime(req_regime), .req_vmid_cur(req_vmid_cur), .req_inner(req_inner),
    .req_excl_xs(req_excl_xs), .req_last(req_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [16:0] observed();
    return {out_vld, unhandled, undef, trap, trap_wide, trap_code,
            req, req_regime, req_vmid_cur, req_inner, req_excl_xs, req_last};
  endfunction

  // expected result vector, same order as observed(), built from the requirements
  function automatic logic [16:0] model(input bit enc_ok, input logic [1:0] lv,
                                        input bit en, input bit wd, input bit t8,
                                        input bit tt, input bit fb, input bit xf,
                                        input bit xe, input bit nx);
    bit uh = 0, ud = 0, tp = 0, tw = 0, rq = 0, rg = 0, vm = 0, inr = 0, ex = 0, ls = 0;
    logic [5:0] cd = 6'h00;
    if (!enc_ok) uh = 1;
    else if (lv == 2'd0) ud = 1;
    else if (lv == 2'd1 && en && (t8 || tt)) begin
      tp = 1; tw = wd; cd = 6'h03;
    end else begin
      rq = 1; ls = 1;
      case (lv)
        2'd1: begin vm = 1; inr = en & fb; ex = en & wd & xf & xe & nx; end
        2'd2: begin vm = 1; end
        default: begin rg = 1; end
      endcase
    end
    return {1'b1, uh, ud, tp, tw, cd, rq, rg, vm, inr, ex, ls};
  endfunction

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [3:0] cp, input logic [2:0] o1,
                       input logic [3:0] rn, input logic [3:0] rm, input logic [2:0] o2,
                       input logic [1:0] lv, input logic [7:0] ctl);
    valid_i = v; coproc = cp; opc1 = o1; crn = rn; crm = rm; opc2 = o2; priv_lvl = lv;
    {l2_en, l2_wide, crn8_trap, tlb_trap, force_bcast, xs_feat, ext_en, no_xs} = ctl;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    drive(1'b1, 4'hF, 3'd0, 4'h8, 4'h7, 3'd5, 2'd3, 8'hFF);
    repeat (3) @(negedge clk);
    // R11: outputs cleared while reset is held, even with a strobe present
    check("R11 reset state", observed(), 17'd0);
    rst_n = 1'b1;
    drive(1'b0, 4'h0, 3'd0, 4'h0, 4'h0, 3'd0, 2'd0, 8'h00);
    repeat (4) @(negedge clk);
    check("R1 idle after reset", observed(), 17'd0);

    // full sweep of level and control bits for the handled encoding, back to back
    for (int c = 0; c < 1024; c++) begin
      logic [1:0] lv;
      logic [7:0] ct;
      string tag;
      lv = c[9:8];
      ct = c[7:0];
      drive(1'b1, 4'hF, 3'd0, 4'h8, 4'h7, 3'd5, lv, ct);
      @(negedge clk);
      if (lv == 2'd0) tag = "R3 level0 undefined";
      else if (lv == 2'd1 && ct[7] && (ct[5] || ct[4])) tag = "R4 trap priority/code/style";
      else if (lv == 2'd1) tag = "R5 R6 R9 R10 level1 request";
      else if (lv == 2'd2) tag = "R7 R9 R10 level2 request";
      else tag = "R8 R9 R10 level3 request";
      check(tag, observed(),
            model(1'b1, lv, ct[7], ct[6], ct[5], ct[4], ct[3], ct[2], ct[1], ct[0]));
      if (c % 16 == 15) begin
        drive(1'b0, 4'hF, 3'd0, 4'h8, 4'h7, 3'd5, lv, ct);
        @(negedge clk);
        check("R1 flags drop after idle", {out_vld, unhandled, undef, trap, req}, 5'd0);
      end
    end

    // R2: each field in turn moved away from the handled value
    for (int f = 0; f < 5; f++) begin
      for (int v = 0; v < 16; v++) begin
        logic [3:0] cp;
        logic [2:0] o1;
        logic [3:0] rn;
        logic [3:0] rm;
        logic [2:0] o2;
        bit skip;
        cp = 4'hF; o1 = 3'd0; rn = 4'h8; rm = 4'h7; o2 = 3'd5; skip = 0;
        case (f)
          0: begin cp = v[3:0]; skip = (v == 15); end
          1: begin o1 = v[2:0]; skip = (v > 7) || (v == 0); end
          2: begin rn = v[3:0]; skip = (v == 8); end
          3: begin rm = v[3:0]; skip = (v == 7); end
          default: begin o2 = v[2:0]; skip = (v > 7) || (v == 5); end
        endcase
        if (!skip) begin
          drive(1'b1, cp, o1, rn, rm, o2, v[1:0], 8'hFF);
          @(negedge clk);
          check("R2 foreign encoding", observed(),
                model(1'b0, v[1:0], 1, 1, 1, 1, 1, 1, 1, 1));
        end
      end
    end

    // R11: reset in mid-run clears an issued request at once
    drive(1'b1, 4'hF, 3'd0, 4'h8, 4'h7, 3'd5, 2'd3, 8'h00);
    @(negedge clk);
    check("R8 request before reset", observed(), model(1'b1, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0));
    rst_n = 1'b0;
    #1;
    check("R11 asynchronous clear", observed(), 17'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 4'hF, 3'd0, 4'h8, 4'h7, 3'd5, 2'd3, 8'h00);
    repeat (3) @(negedge clk);
    drive(1'b1, 4'hF, 3'd0, 4'h8, 4'h7, 3'd5, 2'd1, 8'b1100_0111);
    @(negedge clk);
    check("R6 exclude XS after reset", observed(),
          model(1'b1, 2'd1, 1, 1, 0, 0, 0, 1, 1, 1));
    done = 1;
  end

  initial begin
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule